// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home agent for one memory region in a multiprocessor. For every block of that region it records a coherence state (Uncached, Shared or Exclusive) and a presence vector with one bit per processor, so the directory holds blocks × processors presence bits. Processors send point-to-point read or read-for-ownership requests. The controller then snoops only the processors whose presence bits are set. It never broadcasts.

A processor that wants to write must first get exclusive ownership from this controller. All other holders are invalidated, and the grant is held back until each of them has acknowledged. A read of a line held modified by another processor goes to that owner. The owner's returned data updates the memory copy and is forwarded to the requester, and both then keep shared copies. One transaction is in flight at a time. While it runs, new requests see backpressure.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset, req_ready is 1, snp_valid and gnt_valid are 0, every block is Uncached with an empty presence vector, and every memory word reads as zero.
- R2: A read of an Uncached or Shared block is granted from memory with no snoop. The requester's presence bit is set and the block becomes Shared.
- R3: A read-for-ownership of a Shared block snoops with snp_down=0. snp_mask bit i stands for processor i, and the mask is exactly the recorded sharers minus the requester.
- R4: The grant of a snooped request waits until every snooped processor has acknowledged. An acknowledgement from a processor outside the snoop mask is ignored.
- R5: A read of a block held Exclusive by another processor sends a snoop with snp_down=1 to that owner alone. The owner's ack_data is written to memory and returned as gnt_data, and the block becomes Shared with the owner and the requester both present.
- R6: A read-for-ownership of a block held Exclusive by another processor sends a snoop with snp_down=0 to that owner alone. The owner's ack_data is written to memory and returned as gnt_data.
- R7: After any exclusive grant, the presence vector holds only the new owner. The next conflicting request therefore snoops exactly that one processor.
- R8: A request from the current exclusive owner of a block is granted from memory with no snoop, and the block's state is unchanged.
- R9: Once a request is accepted, req_ready stays 0 until the cycle after its grant. A request held during that time is accepted only afterwards.
- R10: A read-for-ownership from the only sharer of a block is granted with no snoop, and the block becomes Exclusive.
- R11: snp_valid and gnt_valid are each one-cycle pulses per transaction. Acknowledgements carried back from an invalidated sharer (not an owner) do not change memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_src | input | SRC_W | Requesting processor |
| req_excl | input | 1 | 1 = read for ownership, 0 = read |
| req_blk | input | BLK_W | Block index |
| snp_valid | output | 1 | Snoop message valid (one cycle) |
| snp_mask | output | NCPU | Processors that are targeted, bit i = processor i |
| snp_down | output | 1 | 1 = downgrade owner to shared, 0 = invalidate |
| ack_valid | input | 1 | Snoop acknowledgement |
| ack_src | input | SRC_W | Acknowledging processor |
| ack_data | input | DW | Data returned by an owner |
| gnt_valid | output | 1 | Grant to requester (one cycle) |
| gnt_dst | output | SRC_W | Processor receiving the grant |
| gnt_excl | output | 1 | Grant is exclusive |
| gnt_data | output | DW | Block data |

## Verification
The assertions check the following on every cycle:
- A snoop never targets the requester.
- A downgrade always targets exactly one processor.
- An Exclusive entry always has a single presence bit.
- The ack counter always equals the population of the pending mask.
- A grant is issued only once that counter is zero.
- Acceptance always drops req_ready.
- Snoops and grants are single-cycle pulses.

Which processors are snooped for a given history, whether owner data reaches memory and the requester, and whether stray or non-owner acknowledgements leave data alone depend on earlier transactions. The bench shows these through scripted request sequences and the masks and data they produce.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;
  typedef enum logic [1:0] {
    BLK_UNC = 2'd0,
    BLK_SHR = 2'd1,
    BLK_EXC = 2'd2
  } blk_st_e;

  typedef enum logic [1:0] {
    CTL_IDLE  = 2'd0,
    CTL_SNOOP = 2'd1,
    CTL_WAIT  = 2'd2,
    CTL_GRANT = 2'd3
  } ctl_st_e;
endpackage

// File: rtl/coh_dir_store.sv
module coh_dir_store
  import coh_dir_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int NBLK  = 16,
  parameter int DW    = 8,
  localparam int BLK_W = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] rd_blk,
  output blk_st_e          rd_st,
  output logic [NCPU-1:0]  rd_pres,
  output logic [DW-1:0]    rd_data,
  input  logic             dir_we,
  input  logic [BLK_W-1:0] wr_blk,
  input  blk_st_e          wr_st,
  input  logic [NCPU-1:0]  wr_pres,
  input  logic             mem_we,
  input  logic [BLK_W-1:0] mem_blk,
  input  logic [DW-1:0]    mem_wdata
);
  blk_st_e         st_r   [NBLK];
  logic [NCPU-1:0] pres_r [NBLK];
  logic [DW-1:0]   data_r [NBLK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) begin
        st_r[b]   <= BLK_UNC;
        pres_r[b] <= '0;
        data_r[b] <= '0;
      end
    end else begin
      for (int b = 0; b < NBLK; b++) begin
        if (dir_we && (wr_blk == BLK_W'(b))) begin
          st_r[b]   <= wr_st;
          pres_r[b] <= wr_pres;
        end
        if (mem_we && (mem_blk == BLK_W'(b))) begin
          data_r[b] <= mem_wdata;
        end
      end
    end
  end

  assign rd_st   = st_r[rd_blk];
  assign rd_pres = pres_r[rd_blk];
  assign rd_data = data_r[rd_blk];

  // R7: an exclusive entry names exactly one owner
  p_exc_single_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_st == BLK_EXC) |-> $onehot(rd_pres));
endmodule

// File: rtl/coh_ack_track.sv
module coh_ack_track #(
  parameter int NCPU  = 4,
  localparam int SRC_W = $clog2(NCPU),
  localparam int CNT_W = $clog2(NCPU + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NCPU-1:0]  load_mask,
  input  logic             ack_valid,
  input  logic [SRC_W-1:0] ack_src,
  output logic             hit,
  output logic             done
);
  logic [NCPU-1:0]  pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, load_cnt;

  always_comb begin
    load_cnt = '0;
    for (int i = 0; i < NCPU; i++) load_cnt = load_cnt + CNT_W'(load_mask[i]);
  end

  assign hit  = ack_valid && pend_q[ack_src];
  assign done = (cnt_q == '0);

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (load) begin
      pend_d = load_mask;
      cnt_d  = load_cnt;
    end else if (hit) begin
      pend_d[ack_src] = 1'b0;
      cnt_d           = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      cnt_q  <= '0;
    end else if (load || hit) begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  // R4: the counter tracks exactly the outstanding acknowledgements
  p_cnt_matches_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pend_q) == int'(cnt_q));
endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
  import coh_dir_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int NBLK  = 16,
  parameter int DW    = 8,
  localparam int SRC_W = $clog2(NCPU),
  localparam int BLK_W = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SRC_W-1:0] req_src,
  input  logic             req_excl,
  input  logic [BLK_W-1:0] req_blk,
  output logic             snp_valid,
  output logic [NCPU-1:0]  snp_mask,
  output logic             snp_down,
  input  logic             ack_valid,
  input  logic [SRC_W-1:0] ack_src,
  input  logic [DW-1:0]    ack_data,
  output logic             gnt_valid,
  output logic [SRC_W-1:0] gnt_dst,
  output logic             gnt_excl,
  output logic [DW-1:0]    gnt_data
);
  ctl_st_e          state_q, state_d;
  logic [SRC_W-1:0] src_q;
  logic             excl_q, down_q, wb_q, keep_q;
  logic [BLK_W-1:0] blk_q;
  logic [NCPU-1:0]  mask_q;

  logic [BLK_W-1:0] rd_blk;
  blk_st_e          rd_st;
  logic [NCPU-1:0]  rd_pres;
  logic [DW-1:0]    rd_data;
  logic             dir_we;
  blk_st_e          wr_st;
  logic [NCPU-1:0]  wr_pres;

  logic             accept, self_own, need_fetch, need_inv, need_snoop;
  logic [NCPU-1:0]  src_bit, own_bit, others, snoop_mask;
  logic             trk_hit, trk_done, trk_ack;

  assign req_ready  = (state_q == CTL_IDLE);
  assign accept     = req_valid && req_ready;
  assign rd_blk     = (state_q == CTL_IDLE) ? req_blk : blk_q;
  assign src_bit    = NCPU'(1) << req_src;
  assign own_bit    = NCPU'(1) << src_q;
  assign others     = rd_pres & ~src_bit;
  assign self_own   = (rd_st == BLK_EXC) && (rd_pres == src_bit);
  assign need_fetch = (rd_st == BLK_EXC) && !self_own;
  assign need_inv   = req_excl && (rd_st == BLK_SHR) && (|others);
  assign need_snoop = need_fetch || need_inv;
  assign snoop_mask = need_fetch ? rd_pres : others;
  assign trk_ack    = ack_valid && ((state_q == CTL_SNOOP) || (state_q == CTL_WAIT));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CTL_IDLE:  if (accept) state_d = need_snoop ? CTL_SNOOP : CTL_GRANT;
      CTL_SNOOP: state_d = CTL_WAIT;
      CTL_WAIT:  if (trk_done) state_d = CTL_GRANT;
      CTL_GRANT: state_d = CTL_IDLE;
      default:   state_d = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CTL_IDLE;
      src_q   <= '0;
      excl_q  <= 1'b0;
      down_q  <= 1'b0;
      wb_q    <= 1'b0;
      keep_q  <= 1'b0;
      blk_q   <= '0;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        src_q  <= req_src;
        excl_q <= req_excl;
        blk_q  <= req_blk;
        down_q <= need_fetch && !req_excl;
        wb_q   <= need_fetch;
        keep_q <= self_own;
        mask_q <= need_snoop ? snoop_mask : '0;
      end
    end
  end

  assign dir_we  = (state_q == CTL_GRANT) && !keep_q;
  assign wr_st   = excl_q ? BLK_EXC : BLK_SHR;
  assign wr_pres = excl_q ? own_bit : (rd_pres | own_bit);

  coh_ack_track #(.NCPU(NCPU)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && need_snoop),
    .load_mask (snoop_mask),
    .ack_valid (trk_ack),
    .ack_src   (ack_src),
    .hit       (trk_hit),
    .done      (trk_done)
  );

  coh_dir_store #(.NCPU(NCPU), .NBLK(NBLK), .DW(DW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_blk    (rd_blk),
    .rd_st     (rd_st),
    .rd_pres   (rd_pres),
    .rd_data   (rd_data),
    .dir_we    (dir_we),
    .wr_blk    (blk_q),
    .wr_st     (wr_st),
    .wr_pres   (wr_pres),
    .mem_we    (trk_hit && wb_q),
    .mem_blk   (blk_q),
    .mem_wdata (ack_data)
  );

  assign snp_valid = (state_q == CTL_SNOOP);
  assign snp_mask  = mask_q;
  assign snp_down  = down_q;
  assign gnt_valid = (state_q == CTL_GRANT);
  assign gnt_dst   = src_q;
  assign gnt_excl  = excl_q;
  assign gnt_data  = rd_data;

  // R3: the requester is never among the snooped processors
  p_snp_skips_requester_r3: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !snp_mask[src_q]);
  // R5: a downgrade goes to the single owner
  p_down_single_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_down) |-> $onehot(snp_mask));
  // R4: no grant while acknowledgements are outstanding
  p_gnt_after_acks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> trk_done);
  // R9: acceptance closes the request port
  p_accept_stalls_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R11: snoop and grant are single-cycle pulses
  p_snp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> !snp_valid);
  p_gnt_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |=> (!gnt_valid && req_ready));
endmodule

// File: tb/coh_dir_ctrl_bench.sv
module coh_dir_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 4;
  localparam int NBLK = 16;
  localparam int DW   = 8;
  localparam int NV   = 14;
  localparam int VW   = 29;

  // {src[2], excl, blk[4], snoop, down, mask[4], ack data[8], grant data[8]}
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd0, 1'b0, 4'd1, 1'b0, 1'b0, 4'b0000, 8'h00, 8'h00},
    {2'd1, 1'b0, 4'd1, 1'b0, 1'b0, 4'b0000, 8'h00, 8'h00},
    {2'd2, 1'b1, 4'd1, 1'b1, 1'b0, 4'b0011, 8'hAA, 8'h00},
    {2'd3, 1'b0, 4'd1, 1'b1, 1'b1, 4'b0100, 8'h5C, 8'h5C},
    {2'd3, 1'b1, 4'd1, 1'b1, 1'b0, 4'b0100, 8'hEE, 8'h5C},
    {2'd0, 1'b1, 4'd1, 1'b1, 1'b0, 4'b1000, 8'h77, 8'h77},
    {2'd0, 1'b0, 4'd1, 1'b0, 1'b0, 4'b0000, 8'h00, 8'h77},
    {2'd1, 1'b0, 4'd1, 1'b1, 1'b1, 4'b0001, 8'h91, 8'h91},
    {2'd0, 1'b1, 4'd1, 1'b1, 1'b0, 4'b0010, 8'h12, 8'h91},
    {2'd2, 1'b1, 4'd2, 1'b0, 1'b0, 4'b0000, 8'h00, 8'h00},
    {2'd2, 1'b1, 4'd2, 1'b0, 1'b0, 4'b0000, 8'h00, 8'h00},
    {2'd1, 1'b0, 4'd3, 1'b0, 1'b0, 4'b0000, 8'h00, 8'h00},
    {2'd1, 1'b1, 4'd3, 1'b0, 1'b0, 4'b0000, 8'h00, 8'h00},
    {2'd0, 1'b1, 4'd3, 1'b1, 1'b0, 4'b0010, 8'h3E, 8'h3E}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_excl;
  logic [1:0]    req_src;
  logic [3:0]    req_blk;
  logic          snp_valid, snp_down;
  logic [3:0]    snp_mask;
  logic          ack_valid;
  logic [1:0]    ack_src;
  logic [DW-1:0] ack_data;
  logic          gnt_valid, gnt_excl;
  logic [1:0]    gnt_dst;
  logic [DW-1:0] gnt_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_dir_ctrl #(.NCPU(NCPU), .NBLK(NBLK), .DW(DW)) u_coh_dir_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
    .req_excl(req_excl), .req_blk(req_blk),
    .snp_valid(snp_valid), .snp_mask(snp_mask), .snp_down(snp_down),
    .ack_valid(ack_valid), .ack_src(ack_src), .ack_data(ack_data),
    .gnt_valid(gnt_valid), .gnt_dst(gnt_dst), .gnt_excl(gnt_excl),
    .gnt_data(gnt_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_ack(input logic [1:0] src, input logic [DW-1:0] d);
    ack_valid = 1'b1; ack_src = src; ack_data = d;
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  task automatic wait_gnt(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 20 && !seen; k++) begin
      if (gnt_valid) seen = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic run_req(input logic [1:0] src, input logic excl, input logic [3:0] blk,
                         input logic e_snp, input logic e_down, input logic [3:0] e_mask,
                         input logic [DW-1:0] ackd, input logic [DW-1:0] e_gnt);
    bit seen;
    req_valid = 1'b1; req_src = src; req_excl = excl; req_blk = blk;
    @(negedge clk);
    req_valid = 1'b0;
    chk(snp_valid == e_snp, "R2 R3 R8 R10 snoop present", snp_valid, e_snp);
    if (e_snp) begin
      chk(snp_mask == e_mask, "R3 R5 R6 R7 snoop mask", snp_mask, e_mask);
      chk(snp_down == e_down, "R5 R6 snoop kind", snp_down, e_down);
      @(negedge clk);
      for (int i = 0; i < NCPU; i++) if (e_mask[i]) send_ack(2'(i), ackd);
    end
    wait_gnt(seen);
    chk(seen, "R4 grant issued", seen, 1);
    chk(gnt_dst == src && gnt_excl == excl, "R2 grant target",
        {gnt_dst, gnt_excl}, {src, excl});
    chk(gnt_data == e_gnt, "R2 R5 R6 R11 grant data", gnt_data, e_gnt);
    @(negedge clk);
    chk(!gnt_valid && req_ready, "R11 grant pulse", gnt_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit seen;
    rst_n = 1'b0; req_valid = 1'b0; req_src = '0; req_excl = 1'b0; req_blk = '0;
    ack_valid = 1'b0; ack_src = '0; ack_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !snp_valid && !gnt_valid, "R1 reset outputs",
        {req_ready, snp_valid, gnt_valid}, 3'b100);

    for (int v = 0; v < NV; v++) begin
      run_req(VEC[v][28:27], VEC[v][26], VEC[v][25:22], VEC[v][21], VEC[v][20],
              VEC[v][19:16], VEC[v][15:8], VEC[v][7:0]);
    end

    // R4: two of three acks leave the grant pending
    run_req(2'd0, 1'b0, 4'd6, 1'b0, 1'b0, 4'b0000, 8'h00, 8'h00);
    run_req(2'd1, 1'b0, 4'd6, 1'b0, 1'b0, 4'b0000, 8'h00, 8'h00);
    run_req(2'd2, 1'b0, 4'd6, 1'b0, 1'b0, 4'b0000, 8'h00, 8'h00);
    req_valid = 1'b1; req_src = 2'd3; req_excl = 1'b1; req_blk = 4'd6;
    @(negedge clk);
    req_valid = 1'b0;
    chk(snp_valid && snp_mask == 4'b0111, "R3 three sharers", snp_mask, 4'b0111);
    @(negedge clk);
    send_ack(2'd0, 8'h01);
    send_ack(2'd2, 8'h02);
    repeat (3) @(negedge clk);
    chk(!gnt_valid, "R4 grant held for last ack", gnt_valid, 0);
    send_ack(2'd1, 8'h03);
    wait_gnt(seen);
    chk(seen && gnt_dst == 2'd3 && gnt_data == 8'h00, "R4 R11 grant after all acks",
        gnt_data, 8'h00);
    @(negedge clk);

    // R9 and R4: backpressure and a stray acknowledgement
    run_req(2'd1, 1'b0, 4'd5, 1'b0, 1'b0, 4'b0000, 8'h00, 8'h00);
    req_valid = 1'b1; req_src = 2'd2; req_excl = 1'b1; req_blk = 4'd5;
    @(negedge clk);
    chk(snp_valid && snp_mask == 4'b0010, "R3 single sharer invalidated", snp_mask, 4'b0010);
    req_src = 2'd3; req_excl = 1'b0;
    @(negedge clk);
    chk(!req_ready, "R9 stalled while waiting", req_ready, 0);
    send_ack(2'd3, 8'hFF);
    repeat (2) @(negedge clk);
    chk(!gnt_valid && !req_ready, "R4 stray ack ignored", gnt_valid, 0);
    send_ack(2'd1, 8'h00);
    wait_gnt(seen);
    chk(seen && gnt_dst == 2'd2 && gnt_excl, "R9 first request granted first", gnt_dst, 2);
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(snp_valid && snp_down && snp_mask == 4'b0100, "R9 R5 held request then served",
        snp_mask, 4'b0100);
    @(negedge clk);
    send_ack(2'd2, 8'h42);
    wait_gnt(seen);
    chk(seen && gnt_dst == 2'd3 && gnt_data == 8'h42, "R5 owner data forwarded", gnt_data, 8'h42);
    @(negedge clk);

    // R1: reset returns every block to Uncached with zero data
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_req(2'd3, 1'b1, 4'd1, 1'b0, 1'b0, 4'b0000, 8'h00, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule